// File: doc/BRIEF.md
# Operand-2 Barrel Shifter

This is a purely combinational block that produces the second ALU operand and the shifter carry from the 12-bit operand field of a data-processing instruction. It has two forms, selected by a single input that mirrors instruction bit 25.

In the immediate form, an 8-bit constant is rotated right by an even amount. In the register form, a register value is shifted left or right, shifted arithmetically, or rotated. The shift amount comes either from a 5-bit field in the instruction or from the low byte of a second register. The current C flag comes in as a carry input. The block follows the usual special encodings for zero and large shift amounts, so the carry it sends to the ALU is correct in every case. Instruction decode and register reads are done elsewhere; this block only sees the field, the two register values and the flag.

Top module: `operand2_shifter`

## Requirements
- R1: With `imm_form`=1, `operand_b` equals the zero-extended `op_field[7:0]` rotated right by 2×`op_field[11:8]`.
- R2: With `imm_form`=1, `shift_carry` equals `c_flag` when `op_field[11:8]`=0, and equals `operand_b[31]` otherwise.
- R3: With `imm_form`=0, `op_field[6:5]` selects the operation (00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right). `op_field[4]`=0 takes the amount from `op_field[11:7]`; `op_field[4]`=1 takes it from `rs_val[7:0]`, and `rs_val[31:8]` has no effect.
- R4: A left shift by n in 1..31 gives `rm_val<<n`, with carry `rm_val[32-n]`.
- R5: A logical or arithmetic right shift by n in 1..31 gives the shifted value (zero fill or sign fill), with carry `rm_val[n-1]`.
- R6: A rotate right by n in 1..31 gives the rotated value, with carry `rm_val[n-1]`.
- R7: A left shift with an instruction amount of 0 passes `rm_val` unchanged, with carry `c_flag`.
- R8: A logical or arithmetic right shift with an instruction amount of 0 acts as a shift by 32: the result is 0 or all sign bits, and the carry is `rm_val[31]`.
- R9: A rotate with an instruction amount of 0 is a one-bit rotate through carry: the result is {`c_flag`, `rm_val[31:1]`} and the carry is `rm_val[0]`.
- R10: With a register amount of 0, every operation passes `rm_val` unchanged, with carry `c_flag`.
- R11: With a register amount of exactly 32, left and logical right shifts give 0, with carry `rm_val[0]` and `rm_val[31]` respectively.
- R12: With a register amount above 32, left and logical right shifts give 0 with carry 0. With an amount of 32 or more, an arithmetic right shift gives all sign bits with carry `rm_val[31]`.
- R13: With a register amount of 32 or more, a rotate uses the amount mod 32. When that remainder is 0, the result is `rm_val` with carry `rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_form | input | 1 | 1 selects the rotated-immediate form, 0 the shifted-register form |
| op_field | input | 12 | Operand field of the instruction |
| rm_val | input | 32 | Value to be shifted |
| rs_val | input | 32 | Register holding the shift amount (low byte used) |
| c_flag | input | 1 | Current carry flag |
| operand_b | output | 32 | Second ALU operand |
| shift_carry | output | 1 | Shifter carry-out for the ALU |

## Verification
The block holds no state, so any wrong case selection or wrong amount handling shows up at `operand_b` or `shift_carry` as soon as the inputs settle, within the same cycle. The bench works out each expected value by moving bits one position at a time for n steps, tracking the last bit that leaves the word. Because large amounts fall out of that stepping on their own, a clamping or boundary error at 32 or 33 shows up as a mismatch on that very vector. Directed vectors cover every special encoding. Random vectors with large `rs_val` low bytes and noisy upper bytes catch selection mistakes.

// File: rtl/operand2_shifter.sv
module operand2_shifter (
  input  logic        imm_form,
  input  logic [11:0] op_field,
  input  logic [31:0] rm_val,
  input  logic [31:0] rs_val,
  input  logic        c_flag,
  output logic [31:0] operand_b,
  output logic        shift_carry
);
  localparam logic [1:0] SH_LL = 2'b00, SH_LR = 2'b01, SH_AR = 2'b10, SH_RR = 2'b11;

  wire unused_rs_hi = ^rs_val[31:8];

  logic [1:0]  kind;
  logic [7:0]  amt;
  logic        imm_zero;
  logic [5:0]  clamp33, clamp32, rot6;
  logic [32:0] ext;
  logic [31:0] imm_val;
  logic [5:0]  imm_rot;

  assign kind     = op_field[6:5];
  assign amt      = op_field[4] ? rs_val[7:0] : {3'b000, op_field[11:7]};
  assign imm_zero = !op_field[4] && (op_field[11:7] == 5'd0);
  assign clamp33  = (imm_zero || amt == 8'd32) ? 6'd32 : (amt > 8'd32) ? 6'd33 : amt[5:0];
  assign clamp32  = (imm_zero || amt >= 8'd32) ? 6'd32 : amt[5:0];
  assign rot6     = {1'b0, amt[4:0]};
  assign imm_val  = {24'd0, op_field[7:0]};
  assign imm_rot  = {1'b0, op_field[11:8], 1'b0};

  always_comb begin
    ext         = 33'd0;
    operand_b   = rm_val;
    shift_carry = c_flag;
    if (imm_form) begin
      operand_b   = (imm_val >> imm_rot) | (imm_val << (6'd32 - imm_rot));
      shift_carry = (imm_rot == 6'd0) ? c_flag : operand_b[31];
    end else if (amt == 8'd0 && !imm_zero) begin
      operand_b   = rm_val;
      shift_carry = c_flag;
    end else begin
      unique case (kind)
        SH_LL: begin
          if (!imm_zero) begin
            ext         = {1'b0, rm_val} << clamp33;
            operand_b   = ext[31:0];
            shift_carry = ext[32];
          end
        end
        SH_LR: begin
          ext         = {rm_val, 1'b0} >> clamp33;
          operand_b   = ext[32:1];
          shift_carry = ext[0];
        end
        SH_AR: begin
          ext         = $signed({rm_val, 1'b0}) >>> clamp32;
          operand_b   = ext[32:1];
          shift_carry = ext[0];
        end
        SH_RR: begin
          if (imm_zero) begin
            operand_b   = {c_flag, rm_val[31:1]};
            shift_carry = rm_val[0];
          end else begin
            operand_b   = (rm_val >> rot6) | (rm_val << (6'd32 - rot6));
            shift_carry = operand_b[31];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module operand2_shifter_chk (
  input logic        imm_form,
  input logic [11:0] op_field,
  input logic [31:0] rm_val,
  input logic [31:0] rs_val,
  input logic        c_flag,
  input logic [31:0] operand_b,
  input logic        shift_carry
);
  wire unused_chk_hi = ^rs_val[31:8];

  always_comb begin
    if (imm_form && op_field[11:8] == 4'd0) begin
      assert_imm_norot_R1: assert (operand_b == {24'd0, op_field[7:0]});
      assert_imm_keepc_R2: assert (shift_carry == c_flag);
    end
    if (imm_form && op_field[11:8] != 4'd0)
      assert_imm_carry_R2: assert (shift_carry == operand_b[31]);
    if (!imm_form && op_field[4] && rs_val[7:0] == 8'd0)
      assert_reg_zero_R10: assert (operand_b == rm_val && shift_carry == c_flag);
    if (!imm_form && op_field[4] && !op_field[6] && rs_val[7:0] > 8'd32)
      assert_big_clear_R12: assert (operand_b == 32'd0 && !shift_carry);
    if (!imm_form && op_field[4] && op_field[6:5] == 2'b10 && rs_val[7:0] >= 8'd32)
      assert_asr_fill_R12: assert (operand_b == {32{rm_val[31]}} && shift_carry == rm_val[31]);
    if (!imm_form && !op_field[4] && op_field[11:7] == 5'd0 && op_field[6:5] == 2'b11)
      assert_rrx_R9: assert (operand_b == {c_flag, rm_val[31:1]} && shift_carry == rm_val[0]);
  end
endmodule

bind operand2_shifter operand2_shifter_chk chk (.*);

// File: tb/operand2_shifter_test.sv
module operand2_shifter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        imm_form, c_flag;
  logic [11:0] op_field;
  logic [31:0] rm_val, rs_val, operand_b;
  logic        shift_carry;

  operand2_shifter uut (.*);

  int checks = 0, errors = 0;
  logic [31:0] exp_v;
  logic        exp_c;
  string       exp_tag;
  bit          armed = 0;
  int          cycles = 0;

  task automatic model(input bit im, input logic [11:0] f, input logic [31:0] m, s,
                       input bit ci, output logic [31:0] v, output bit c, output string tag);
    int n, ty;
    v = m; c = ci;
    if (im) begin
      v = {24'd0, f[7:0]};
      for (int i = 0; i < 2 * f[11:8]; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
      tag = (f[11:8] == 0) ? "R2" : "R1";
      return;
    end
    ty = f[6:5];
    n = f[4] ? int'(s[7:0]) : int'(f[11:7]);
    if (!f[4] && n == 0) begin
      if (ty == 0) begin tag = "R7"; return; end
      if (ty == 3) begin c = m[0]; v = {ci, m[31:1]}; tag = "R9"; return; end
      n = 32; tag = "R8";
    end else if (n == 0) tag = "R10";
    else if (n < 32) tag = (ty == 0) ? "R4" : (ty == 3) ? "R6" : "R5";
    else if (n == 32) tag = (ty == 3) ? "R13" : (ty == 2) ? "R12" : "R11";
    else tag = (ty == 3) ? "R13" : "R12";
    if (f[4]) tag = {tag, "/R3"};
    for (int i = 0; i < n; i++) begin
      case (ty)
        0: begin c = v[31]; v = v << 1; end
        1: begin c = v[0]; v = v >> 1; end
        2: begin c = v[0]; v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
  endtask

  task automatic apply(input bit im, input logic [11:0] f, input logic [31:0] m, s, input bit ci);
    @(posedge clk);
    imm_form = im; op_field = f; rm_val = m; rs_val = s; c_flag = ci;
    model(im, f, m, s, ci, exp_v, exp_c, exp_tag);
    armed = 1;
  endtask

  always @(negedge clk) if (armed) begin
    checks++;
    if (operand_b !== exp_v || shift_carry !== exp_c) begin
      errors++;
      $display("FAIL %s: got %h/%b expected %h/%b (imm=%b field=%h rm=%h rs=%h c=%b)",
               exp_tag, operand_b, shift_carry, exp_v, exp_c, imm_form, op_field, rm_val, rs_val, c_flag);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    imm_form = 0; op_field = 0; rm_val = 0; rs_val = 0; c_flag = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    apply(0, 12'h000, 32'h0, 32'h0, 0);                   // reset-state pattern, R7
    apply(1, 12'h0A5, 32'h0, 32'h0, 1);                   // R1 R2 rotate 0
    apply(1, 12'h1FF, 32'h0, 32'h0, 0);                   // R1 rotate by 2
    apply(1, 12'hF81, 32'h0, 32'h0, 0);                   // R1 R2 rotate by 30
    apply(0, {5'd0, 2'b00, 1'b0, 4'h0}, 32'h8000_0001, 0, 1); // R7
    apply(0, {5'd0, 2'b01, 1'b0, 4'h0}, 32'h8000_0001, 0, 0); // R8 LSR #32
    apply(0, {5'd0, 2'b10, 1'b0, 4'h0}, 32'h8000_0001, 0, 0); // R8 ASR #32
    apply(0, {5'd0, 2'b11, 1'b0, 4'h0}, 32'h8000_0001, 0, 1); // R9 RRX
    apply(0, {5'd1, 2'b00, 1'b0, 4'h0}, 32'hC000_0000, 0, 0); // R4
    apply(0, {5'd31, 2'b10, 1'b0, 4'h0}, 32'h8000_0000, 0, 0); // R5
    apply(0, {5'd4, 2'b11, 1'b0, 4'h0}, 32'h0000_0018, 0, 0);  // R6
    for (int t = 0; t < 4; t++) begin
      apply(0, {5'd0, t[1:0], 1'b1, 4'h0}, 32'h8765_4321, 32'hFFFF_FF00, 1); // R10 R3
      apply(0, {5'd0, t[1:0], 1'b1, 4'h0}, 32'h8765_4321, 32'h0000_0020, 0); // R11 R12 R13
      apply(0, {5'd0, t[1:0], 1'b1, 4'h0}, 32'h8765_4321, 32'h0000_0021, 1); // R12 R13
      apply(0, {5'd0, t[1:0], 1'b1, 4'h0}, 32'hF765_4321, 32'h1234_56C8, 1); // R12 R13 R3
      apply(0, {5'd0, t[1:0], 1'b1, 4'h0}, 32'h8765_4321, 32'hAB00_0040, 0); // R13 R3
    end
    for (int k = 0; k < 3000; k++)
      apply(k[0] & k[3], 12'($urandom), $urandom, $urandom, 1'($urandom));
    @(posedge clk); armed = 0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule